// File: doc/BRIEF.md
# Output Queue Congestion Discard Controller

This block makes the admission and marking decision for each cell that arrives at one output port. The cell's continuous-stream bit picks one of two queues: the stream queue, for constant- and variable-rate traffic, or the best-effort queue, for available- and unspecified-rate traffic. The queues themselves are kept outside the block. Their current occupancies come in as inputs, together with a set of per-queue thresholds from configuration. For every cell the controller decides to accept or drop it. For every accepted cell it also decides whether to set the forward congestion indication bit.

Each cell may carry a block-discard index. When the index is nonzero, the block applies packet-level discard to that cell. It keeps a small state entry for each index. Early discard, which has hysteresis per queue, refuses a packet whose first cell arrives while that queue's discard mode is on. Partial discard then drops the rest of any packet that has already lost a cell, but keeps the packet's final cell so that the packet boundary survives downstream. A saturating counter records how many cells have been dropped. Each decision appears on the outputs one clock after the cell is presented.

Top module: `cqd_ctrl`

## Requirements
- R1: `in_stream`=1 selects queue 1 (stream) and `in_stream`=0 selects queue 0 (best-effort). The decision for a cell uses only the occupancy and thresholds at the selected index of the `occ`, `cong_thr`, `epd_hi` and `epd_lo` vectors.
- R2: A cell with index 0 is dropped exactly when `in_clp`=1 and the selected occupancy is strictly greater than its `cong_thr`. Any other index-0 cell is accepted.
- R3: An accepted cell has `out_mark`=1 exactly when the selected occupancy is strictly greater than its `cong_thr`. A dropped cell never has `out_mark`=1.
- R4: Each queue has an early-discard mode that is re-evaluated every cycle. It turns on when that queue's occupancy is strictly above `epd_hi`, turns off when it is strictly below `epd_lo`, and otherwise keeps its previous value. The value used for a cell already includes that cycle's occupancy.
- R5: A cell with nonzero index that starts a packet while its queue's early-discard mode is on is dropped. All later cells of that packet on the same index are dropped too, including the final cell, which is marked by `in_eop`=1.
- R6: When a cell of an admitted packet with nonzero index is dropped because of loss priority (`in_clp`=1 while its queue is above `cong_thr`), the later non-final cells of that packet are dropped regardless of their own priority. The packet's final cell is accepted.
- R7: Early discard never affects index-0 cells: with the mode on, an index-0 cell with `in_clp`=0 is accepted.
- R8: Packet state is held separately for each nonzero index. Cells on one index do not change decisions for another index, and a cell with `in_eop`=1 returns its index to the packet-start state.
- R9: `drop_count` increases by one for each dropped cell, in the same cycle that `out_drop` shows the drop, and stays at its all-ones value once it reaches it.
- R10: When a cell is presented with `in_valid`=1, exactly one of `out_accept` and `out_drop` is high on the next cycle, together with `out_valid`. Without a cell, all three are low.
- R11: While `rst` is high, the outputs and `drop_count` are zero, every index returns to the packet-start state and both early-discard modes turn off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A cell is presented this cycle |
| in_stream | input | 1 | Continuous-stream bit: 1 selects the stream queue, 0 the best-effort queue |
| in_clp | input | 1 | Loss-priority bit of the cell |
| in_eop | input | 1 | Cell is the last of its packet |
| in_bdi | input | BDI_W | Block-discard index; 0 means no packet tracking |
| occ | input | 2*QW | Occupancy of each queue, index 1 = stream |
| cong_thr | input | 2*QW | Congestion threshold per queue |
| epd_hi | input | 2*QW | Early-discard turn-on threshold per queue |
| epd_lo | input | 2*QW | Early-discard turn-off threshold per queue |
| out_valid | output | 1 | A decision is presented |
| out_accept | output | 1 | Cell is admitted |
| out_drop | output | 1 | Cell is discarded |
| out_mark | output | 1 | Set the forward congestion indication bit on the admitted cell |
| drop_count | output | CNT_W | Saturating count of dropped cells |

## Verification
The hardest situation to reach from the ports is an early-discard mode held on by hysteresis while the occupancy sits between the two thresholds, and at that moment a new packet starting on an index whose previous packet was being trimmed. The directed part of the stimulus walks the occupancy above, between and below the thresholds while it opens and closes single- and multi-cell packets. The random part keeps a few indices interleaved, with occupancies spread across all the threshold bands, so that trimmed, purged and admitted packets overlap on different indices. With a narrowed counter width, the random part also drives the drop counter into saturation.

// File: rtl/cqd_pkg.sv
package cqd_pkg;

    localparam int NUM_Q = 2;

    typedef enum logic [1:0] {
        PK_IDLE  = 2'd0,
        PK_PASS  = 2'd1,
        PK_TRIM  = 2'd2,
        PK_PURGE = 2'd3
    } pk_state_e;

    typedef struct packed {
        logic      drop;
        logic      mark;
        pk_state_e nxt;
    } verdict_t;

    // Accept/drop/mark decision for one cell plus the next packet state of its index
    function automatic verdict_t judge(
        input pk_state_e st,
        input logic      tracked,
        input logic      eop,
        input logic      clp,
        input logic      cong,
        input logic      epd_on
    );
        verdict_t v;
        v.nxt  = st;
        v.drop = 1'b0;
        if (!tracked) begin
            v.drop = clp & cong;
        end else begin
            unique case (st)
                PK_TRIM: begin
                    v.drop = ~eop;
                    v.nxt  = eop ? PK_IDLE : PK_TRIM;
                end
                PK_PURGE: begin
                    v.drop = 1'b1;
                    v.nxt  = eop ? PK_IDLE : PK_PURGE;
                end
                default: begin
                    if (st == PK_IDLE && epd_on) begin
                        v.drop = 1'b1;
                        v.nxt  = eop ? PK_IDLE : PK_PURGE;
                    end else begin
                        v.drop = clp & cong;
                        v.nxt  = eop ? PK_IDLE : (v.drop ? PK_TRIM : PK_PASS);
                    end
                end
            endcase
        end
        v.mark = ~v.drop & cong;
        return v;
    endfunction

endpackage

// File: rtl/cqd_hyst.sv
module cqd_hyst #(
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [QW-1:0] occ,
    input  logic [QW-1:0] hi,
    input  logic [QW-1:0] lo,
    output logic          epd_eff
);
    logic mode_q;

    always_comb begin
        if (occ > hi)      epd_eff = 1'b1;
        else if (occ < lo) epd_eff = 1'b0;
        else               epd_eff = mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= epd_eff;
    end

    assert_hyst_on_R4: assert property (@(posedge clk) disable iff (rst)
        (occ > hi) |=> mode_q);
    assert_hyst_off_R4: assert property (@(posedge clk) disable iff (rst)
        (occ < lo && !(occ > hi)) |=> !mode_q);
    assert_hyst_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!(occ > hi) && !(occ < lo)) |=> (mode_q == $past(mode_q)));
endmodule

// File: rtl/cqd_pkt_table.sv
module cqd_pkt_table
    import cqd_pkg::*;
#(
    parameter int BDI_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BDI_W-1:0] rd_idx,
    output pk_state_e        rd_state,
    input  logic             wr_en,
    input  logic [BDI_W-1:0] wr_idx,
    input  pk_state_e        wr_state
);
    localparam int DEPTH = 1 << BDI_W;

    pk_state_e tbl [DEPTH];

    assign rd_state = tbl[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= PK_IDLE;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_state;
        end
    end

    assert_untracked_idle_R8: assert property (@(posedge clk) disable iff (rst)
        tbl[0] == PK_IDLE);
endmodule

// File: rtl/cqd_sat_ctr.sv
module cqd_sat_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (inc && cnt != CMAX) cnt <= cnt + 1'b1;
    end

    assert_ctr_step_R9: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt != CMAX) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    assert_ctr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!inc || cnt == CMAX) |=> $stable(cnt));
endmodule

// File: rtl/cqd_ctrl.sv
module cqd_ctrl
    import cqd_pkg::*;
#(
    parameter int QW    = 8,
    parameter int BDI_W = 4,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_stream,
    input  logic                    in_clp,
    input  logic                    in_eop,
    input  logic [BDI_W-1:0]        in_bdi,
    input  logic [NUM_Q-1:0][QW-1:0] occ,
    input  logic [NUM_Q-1:0][QW-1:0] cong_thr,
    input  logic [NUM_Q-1:0][QW-1:0] epd_hi,
    input  logic [NUM_Q-1:0][QW-1:0] epd_lo,
    output logic                    out_valid,
    output logic                    out_accept,
    output logic                    out_drop,
    output logic                    out_mark,
    output logic [CNT_W-1:0]        drop_count
);
    logic [NUM_Q-1:0] epd_eff;
    logic [NUM_Q-1:0] cong_vec;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        cqd_hyst #(.QW(QW)) u_hyst (
            .clk     (clk),
            .rst     (rst),
            .occ     (occ[g]),
            .hi      (epd_hi[g]),
            .lo      (epd_lo[g]),
            .epd_eff (epd_eff[g])
        );
        assign cong_vec[g] = occ[g] > cong_thr[g];
    end

    pk_state_e cur_state;
    verdict_t  vd;
    logic      tracked;
    logic      cell_drop;

    assign tracked = in_bdi != '0;

    cqd_pkt_table #(.BDI_W(BDI_W)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (in_bdi),
        .rd_state (cur_state),
        .wr_en    (in_valid && tracked),
        .wr_idx   (in_bdi),
        .wr_state (vd.nxt)
    );

    always_comb begin
        vd = judge(cur_state, tracked, in_eop, in_clp,
                   cong_vec[in_stream], epd_eff[in_stream]);
    end

    assign cell_drop = in_valid && vd.drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_accept <= 1'b0;
            out_drop   <= 1'b0;
            out_mark   <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            out_accept <= in_valid && !vd.drop;
            out_drop   <= cell_drop;
            out_mark   <= in_valid && vd.mark;
        end
    end

    cqd_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk (clk),
        .rst (rst),
        .inc (cell_drop),
        .cnt (drop_count)
    );

    assert_one_verdict_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot({out_accept, out_drop}));
    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(out_accept || out_drop || out_mark));
    assert_mark_accepted_R3: assert property (@(posedge clk) disable iff (rst)
        out_mark |-> out_accept);
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid) |-> out_valid);
    assert_trim_keeps_tail_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && tracked && cur_state == PK_TRIM && in_eop) |=> out_accept);
endmodule

// File: tb/tb_cqd_ctrl.sv
module tb_cqd_ctrl;
    localparam int QW    = 8;
    localparam int BDI_W = 4;
    localparam int CNT_W = 5;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_stream, in_clp, in_eop;
    logic [BDI_W-1:0] in_bdi;
    logic [1:0][QW-1:0] occ, cong_thr, epd_hi, epd_lo;
    logic out_valid, out_accept, out_drop, out_mark;
    logic [CNT_W-1:0] drop_count;

    always #2.5 clk = ~clk;

    cqd_ctrl #(.QW(QW), .BDI_W(BDI_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_stream(in_stream),
        .in_clp(in_clp), .in_eop(in_eop), .in_bdi(in_bdi), .occ(occ),
        .cong_thr(cong_thr), .epd_hi(epd_hi), .epd_lo(epd_lo),
        .out_valid(out_valid), .out_accept(out_accept), .out_drop(out_drop),
        .out_mark(out_mark), .drop_count(drop_count)
    );

    int checks = 0;
    int fails  = 0;

    // reference state: 0 start, 1 admitted, 2 trimming, 3 purging
    int m_st [16];
    int m_epd [2];
    int m_cnt;
    bit have_exp;
    int e_valid, e_drop, e_mark;
    string e_tag;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare();
        if (!have_exp) return;
        chk({e_tag, " valid"}, out_valid, e_valid);
        chk({e_tag, " accept"}, out_accept, e_valid && !e_drop);
        chk({e_tag, " drop"}, out_drop, e_drop);
        chk("R3 mark", out_mark, e_mark);
        chk("R9 drop_count", drop_count, m_cnt);
    endtask

    task automatic step(input bit v, input bit s, input bit c, input bit e,
                        input int b, input int o0, input int o1);
        int q, o, st, cong, epd_now;
        @(negedge clk);
        compare();
        in_valid = v; in_stream = s; in_clp = c; in_eop = e;
        in_bdi = BDI_W'(b); occ[0] = QW'(o0); occ[1] = QW'(o1);
        for (int k = 0; k < 2; k++) begin
            o = (k == 0) ? o0 : o1;
            if (o > int'(epd_hi[k])) m_epd[k] = 1;
            else if (o < int'(epd_lo[k])) m_epd[k] = 0;
        end
        q = s ? 1 : 0;
        o = s ? o1 : o0;
        cong = (o > int'(cong_thr[q])) ? 1 : 0;
        epd_now = m_epd[q];
        e_valid = v; e_drop = 0; e_tag = "R10";
        if (v) begin
            if (b == 0) begin
                e_drop = c && cong; e_tag = epd_now ? "R7" : "R2";
            end else begin
                st = m_st[b];
                if (st == 3) begin
                    e_drop = 1; e_tag = "R5"; m_st[b] = e ? 0 : 3;
                end else if (st == 2) begin
                    e_drop = !e; e_tag = "R6"; m_st[b] = e ? 0 : 2;
                end else if (st == 0 && epd_now == 1) begin
                    e_drop = 1; e_tag = "R5"; m_st[b] = e ? 0 : 3;
                end else begin
                    e_drop = c && cong; e_tag = "R8";
                    m_st[b] = e ? 0 : (e_drop ? 2 : 1);
                end
            end
        end
        e_mark = e_valid && !e_drop && cong;
        if (e_drop && m_cnt < CMAX) m_cnt++;
        have_exp = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 0; in_stream = 0; in_clp = 0; in_eop = 0;
        in_bdi = '0; occ = '0;
        cong_thr[0] = 8'd100; cong_thr[1] = 8'd40;
        epd_hi[0]   = 8'd180; epd_hi[1]   = 8'd150;
        epd_lo[0]   = 8'd90;  epd_lo[1]   = 8'd60;
        for (int i = 0; i < 16; i++) m_st[i] = 0;
        m_epd[0] = 0; m_epd[1] = 0; m_cnt = 0; have_exp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 valid", out_valid, 0);
        chk("R11 drop", out_drop, 0);
        chk("R11 count", drop_count, 0);
        rst = 1'b0;

        // R1: occupancy 70 congests the stream queue only
        step(1, 1, 1, 1, 0, 70, 70);
        step(1, 0, 1, 1, 0, 70, 70);
        // R2/R3: best-effort above congestion, clp 0 marked, clp 1 dropped
        step(1, 0, 0, 1, 0, 120, 0);
        step(1, 0, 1, 1, 0, 120, 0);
        // R4/R5: EPD on above hi, held between, off below lo
        step(1, 0, 0, 1, 1, 200, 0);
        step(1, 0, 0, 1, 1, 95, 0);
        step(1, 0, 0, 0, 2, 95, 0);
        // R7: index 0 unaffected while EPD on
        step(1, 0, 0, 1, 0, 95, 0);
        step(1, 0, 0, 0, 2, 10, 0);
        step(1, 0, 0, 1, 2, 10, 0);
        step(1, 0, 0, 1, 1, 95, 0);
        // R6: trim after clp drop, tail kept; R8: other index unaffected
        step(1, 0, 0, 0, 3, 10, 0);
        step(1, 0, 1, 0, 3, 120, 0);
        step(1, 0, 0, 0, 3, 10, 0);
        step(1, 0, 0, 0, 4, 10, 0);
        step(1, 0, 0, 1, 3, 10, 0);
        step(1, 0, 0, 1, 4, 10, 0);
        step(1, 0, 0, 1, 3, 10, 0);
        step(0, 0, 0, 0, 0, 10, 0);

        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 4) != 0, $urandom % 2, ($urandom % 3) == 0,
                 ($urandom % 4) == 0, $urandom % 4,
                 $urandom % 256, $urandom % 256);
        end
        step(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        chk("R9 saturated", drop_count, CMAX);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule